// File: doc/BRIEF.md
# Load-Use Stall Controller

This unit sits in the decode stage of a five-stage in-order pipeline. It watches the instruction that has just entered execute and the one waiting in decode. When the execute-stage instruction is a load, and its target register is one that the decode-stage instruction reads, the loaded value will not exist in time, even with forwarding. In that case the unit holds the fetch address and the fetch/decode register for one cycle. It also replaces the control word entering the decode/execute register with zeros, so a no-op follows the load.

The load and everything older keep moving. On the next cycle the execute stage holds the injected no-op, whose load flag is clear, so the condition goes away. The waiting instruction then advances, and the forwarding path from the memory/write-back stage supplies the value. The unit is purely combinational. The clock and reset inputs only pace the built-in property checks.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: A stall is raised when `ex_mem_read` is 1, `ex_rt` is nonzero, and `ex_rt` equals `id_rs` or `id_rt`. A stall is shown as `pc_write`=0, `ifid_write`=0 and `ctrl_zero`=1.
- R2: `pc_write` and `ifid_write` are active high. In every cycle both equal the inverse of `ctrl_zero`.
- R3: While stalling, `ex_ctrl_d` is all zeros. This covers every field of the 9-bit control word. The layout from MSB to LSB is: bit 8 register-destination select, bits 7:6 ALU operation class, bit 5 ALU source select, bit 4 branch, bit 3 memory read, bit 2 memory write, bit 1 register write, bit 0 memory-to-register select.
- R4: While not stalling, `ex_ctrl_d` equals `dec_ctrl` bit for bit.
- R5: When `ex_mem_read` is 0, no stall occurs, even if `ex_rt` matches a decode source register.
- R6: A load whose target is register 0 (`ex_rt`=0) never stalls.
- R7: A dependent instruction causes exactly one stall cycle. In the cycle after a stall, with the no-op in execute, `pc_write` is 1 while the same instruction is still in decode.
- R8: Two back-to-back loads stall only when the second load reads the first load's target. Two independent back-to-back loads do not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| ex_mem_read | input | 1 | Memory-read flag of the instruction in execute |
| ex_rt | input | 5 | Load target register of the instruction in execute |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second source register of the instruction in decode |
| dec_ctrl | input | 9 | Control word produced by the decoder |
| pc_write | output | 1 | Fetch-address write enable |
| ifid_write | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Bubble select: zeroes the control word |
| ex_ctrl_d | output | 9 | Control word to write into decode/execute |

## Verification
The bench surrounds the unit with a small pipeline-register model. In that model, a stall really holds the fetch address and the fetch/decode register and injects a zero control word. It then runs directed sequences followed by a seeded random stream of loads and other instructions. A design that latched the stall would stall twice for one dependent load. That shows up in the cycle after the bubble, when the same instruction is still in decode. A design that ignored register 0 would stall on a load into the zero register. A design that compared only one source field would miss matches on the second source. A design that dropped the load-flag qualifier would stall on ordinary ALU producers. A mux that cleared only some control bits would leak them into the bubble, and the full control-word compare catches that.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

    localparam int REG_W = 5;

    typedef struct packed {
        logic       reg_dst;
        logic [1:0] alu_op;
        logic       alu_src;
        logic       branch;
        logic       mem_read;
        logic       mem_write;
        logic       reg_write;
        logic       mem_to_reg;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } stall_t;

endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
    parameter int RW     = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ex_mem_read,
    input  logic [RW-1:0]             ex_rt,
    input  logic [NUM_SRC-1:0][RW-1:0] srcs,
    output logic                      hazard
);

    logic [NUM_SRC-1:0] match_d;
    logic               tgt_live_d;

    assign tgt_live_d = ex_mem_read && (ex_rt != '0);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_comb begin
            match_d[i] = tgt_live_d && (srcs[i] == ex_rt);
        end
    end

    always_comb begin
        hazard = |match_d;
    end

    // R6
    zero_target_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rt == '0) |-> !hazard);

    // R5
    no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_read |-> !hazard);

endmodule

// File: rtl/ldu_bubble_mux.sv
module ldu_bubble_mux #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_sel,
    input  logic [CW-1:0] ctrl_in,
    output logic [CW-1:0] ctrl_out
);

    always_comb begin
        ctrl_out = zero_sel ? '0 : ctrl_in;
    end

    // R3
    bubble_all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_sel |-> (ctrl_out == '0));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_sel |-> (ctrl_out == ctrl_in));

endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl
    import ldu_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_mem_read,
    input  logic [RW-1:0] ex_rt,
    input  logic [RW-1:0] id_rs,
    input  logic [RW-1:0] id_rt,
    input  logic [CW-1:0] dec_ctrl,
    output logic          pc_write,
    output logic          ifid_write,
    output logic          ctrl_zero,
    output logic [CW-1:0] ex_ctrl_d
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][RW-1:0] src_regs;
    logic                       hazard;
    stall_t                     stall_d;

    assign src_regs[0] = id_rs;
    assign src_regs[1] = id_rt;

    ldu_hazard_detect #(.RW(RW), .NUM_SRC(NUM_SRC)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_mem_read (ex_mem_read),
        .ex_rt       (ex_rt),
        .srcs        (src_regs),
        .hazard      (hazard)
    );

    always_comb begin
        stall_d         = '0;
        stall_d.pc_we   = !hazard;
        stall_d.ifid_we = !hazard;
        stall_d.bubble  = hazard;
    end

    assign pc_write   = stall_d.pc_we;
    assign ifid_write = stall_d.ifid_we;
    assign ctrl_zero  = stall_d.bubble;

    ldu_bubble_mux #(.CW(CW)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_sel (stall_d.bubble),
        .ctrl_in  (dec_ctrl),
        .ctrl_out (ex_ctrl_d)
    );

    // R2
    enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write == ifid_write) && (pc_write != ctrl_zero));

    // R1
    match_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && (ex_rt != '0) && (ex_rt == id_rs)) |-> !pc_write);

    // R7: the injected no-op clears the load flag, so a stall never repeats
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> pc_write);

endmodule

// File: tb/ldu_stall_ctrl_tb.sv
module ldu_stall_ctrl_tb;

    localparam int RW = 5;
    localparam int CW = 9;
    localparam int MR_BIT = 3;
    localparam int NPROG = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ex_mem_read;
    logic [RW-1:0] ex_rt, id_rs, id_rt;
    logic [CW-1:0] dec_ctrl, ex_ctrl_d;
    logic          pc_write, ifid_write, ctrl_zero;

    always #2 clk = ~clk;

    ldu_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ex_mem_read(ex_mem_read), .ex_rt(ex_rt),
        .id_rs(id_rs), .id_rt(id_rt), .dec_ctrl(dec_ctrl),
        .pc_write(pc_write), .ifid_write(ifid_write), .ctrl_zero(ctrl_zero),
        .ex_ctrl_d(ex_ctrl_d)
    );

    // program memory of the pipeline model
    logic [RW-1:0] p_rs [NPROG];
    logic [RW-1:0] p_rt [NPROG];
    logic [CW-1:0] p_ct [NPROG];

    // pipeline model state
    int            pc;
    logic [RW-1:0] fd_rs, fd_rt;
    logic [CW-1:0] fd_ct;
    logic [CW-1:0] de_ct;
    logic [RW-1:0] de_rt;
    logic          prev_stall;
    int            stalls;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign ex_mem_read = de_ct[MR_BIT];
    assign ex_rt       = de_rt;
    assign id_rs       = fd_rs;
    assign id_rt       = fd_rt;
    assign dec_ctrl    = fd_ct;

    function automatic bit exp_stall(logic [CW-1:0] dct, logic [RW-1:0] drt,
                                     logic [RW-1:0] frs, logic [RW-1:0] frt);
        return dct[MR_BIT] && (drt != '0) && ((drt == frs) || (drt == frt));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(int i, logic [RW-1:0] rs, logic [RW-1:0] rt, bit ld);
        p_rs[i] = rs;
        p_rt[i] = rt;
        p_ct[i] = ld ? 9'h06B : 9'h122;
    endtask

    // check at negedge, then advance model
    task automatic step(string tag);
        bit s;
        @(negedge clk);
        s = exp_stall(de_ct, de_rt, fd_rs, fd_rt);
        chk(ctrl_zero == s, {tag, " R1 ctrl_zero"}, ctrl_zero, s);
        chk((pc_write == !s) && (ifid_write == !s), {tag, " R2 enables"},
            {pc_write, ifid_write}, {!s, !s});
        if (s) chk(ex_ctrl_d == '0, {tag, " R3 bubble"}, ex_ctrl_d, 0);
        else   chk(ex_ctrl_d == fd_ct, {tag, " R4 pass"}, ex_ctrl_d, fd_ct);
        if (prev_stall)
            chk(pc_write == 1'b1, {tag, " R7 one stall"}, pc_write, 1);
        prev_stall = s;
        if (s) begin
            stalls++;
            de_ct = '0;
            de_rt = '0;
        end else begin
            de_ct = fd_ct;
            de_rt = fd_rt;
            fd_rs = p_rs[pc % NPROG];
            fd_rt = p_rt[pc % NPROG];
            fd_ct = p_ct[pc % NPROG];
            pc++;
        end
    endtask

    task automatic run_to(int stop_pc, string tag);
        while (pc < stop_pc) step(tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < NPROG; i++) put(i, 5'd0, 5'd0, 1'b0);
        // directed sequence (loads set bit 3; load target in rt)
        put(0, 5'd1, 5'd3, 1);   // lw r3
        put(1, 5'd3, 5'd4, 0);   // uses r3 as rs -> stall (R1, R7)
        put(2, 5'd2, 5'd5, 1);   // lw r5
        put(3, 5'd6, 5'd7, 0);   // independent
        put(4, 5'd1, 5'd2, 1);   // lw r2
        put(5, 5'd2, 5'd4, 1);   // lw r4 with base r2 -> stall (R8)
        put(6, 5'd1, 5'd8, 1);   // lw r8
        put(7, 5'd1, 5'd9, 1);   // lw r9 independent (R8)
        put(8, 5'd1, 5'd0, 1);   // lw r0
        put(9, 5'd0, 5'd0, 0);   // reads r0 -> no stall (R6)
        put(10, 5'd1, 5'd5, 0);  // alu writes, rt=r5
        put(11, 5'd5, 5'd5, 0);  // reads r5, no load -> no stall (R5)
        put(12, 5'd1, 5'd10, 1); // lw r10
        put(13, 5'd11, 5'd10, 0);// rt matches -> stall (R1)
        for (int i = 14; i < NPROG; i++) begin
            logic [CW-1:0] c;
            c = CW'($urandom);
            c[MR_BIT] = ($urandom % 3) == 0;
            p_rs[i] = RW'($urandom % 6);
            p_rt[i] = RW'($urandom % 6);
            p_ct[i] = c;
        end
        pc = 0; fd_rs = '0; fd_rt = '0; fd_ct = '0;
        de_ct = '0; de_rt = '0; prev_stall = 1'b0; stalls = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_write && ifid_write && !ctrl_zero, "reset R2", {pc_write, ifid_write, ctrl_zero}, 3'b110);
        rst_n = 1'b1;
        run_to(3, "lw-dep");
        chk(stalls == 1, "lw-dep R7 count", stalls, 1);
        run_to(5, "lw-indep");
        chk(stalls == 1, "lw-indep R8 count", stalls, 1);
        run_to(7, "lw-lw-dep");
        chk(stalls == 2, "lw-lw-dep R8 count", stalls, 2);
        run_to(10, "lw-lw-indep");
        chk(stalls == 2, "lw-lw-indep R8 R6 count", stalls, 2);
        run_to(13, "no-load");
        chk(stalls == 2, "no-load R5 count", stalls, 2);
        run_to(15, "rt-match");
        chk(stalls == 3, "rt-match R1 count", stalls, 3);
        run_to(NPROG, "random");
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule